// File: doc/BRIEF.md
# Timer Output-Compare Reference Generator

This block is the output-compare stage of a single timer channel. Each clock it compares an external counter value with a compare value. From the active 4-bit mode it then sets the level of an active-high reference signal. The modes are: hold, set on match, clear on match, toggle on match, forced low, forced high, two PWM polarities and two retriggerable one-pulse variants. A second output, the combined reference, mixes this channel's reference with the reference of a paired channel. In the combined modes it is their OR or AND. In the asymmetric modes it picks one of the two by count direction.

The mode field can be written directly or through a shadow copy. When preloading is on, a write lands in the shadow copy, and the active mode only takes that value on a commutation pulse. A lock input, applied while the channel is used as an output, discards mode writes. The counter, output polarity, dead-time and break handling live outside this block.

Top module: `ocref_gen`

## Requirements
- R1: After reset the active mode and the shadow mode are both code 0 (frozen), the one-pulse armed flag is clear, and ref_out and refc_out are low.
- R2: In mode 0 and in the reserved codes 10 and 11, ref_out keeps its level whatever the counter and compare values are.
- R3: In mode 1, ref_out goes high at the clock edge that samples cnt equal to cmp_val. In mode 2 it goes low at that edge. Otherwise it holds.
- R4: In mode 3, ref_out inverts at every clock edge that samples cnt equal to cmp_val, and holds at other edges.
- R5: Mode 4 drives ref_out low and mode 5 drives it high, from the first edge that samples the mode, whatever the counter value is.
- R6: In modes 6, 12 and 14, an edge sets ref_out to (cnt < cmp_val) when cnt_down is 0, and to not (cnt > cmp_val) when cnt_down is 1.
- R7: Modes 7, 13 and 15 give the inverse of the R6 level.
- R8: Mode 8 sets the armed flag on a trig pulse and clears it on an upd pulse, with trig taking priority. The flag applies from the edge that samples the pulse. While armed, ref_out follows the R6 level. While not armed, ref_out is high when counting up and low when counting down. Outside modes 8 and 9 the flag is cleared.
- R9: Mode 9 arms and disarms as in R8. While armed, ref_out follows the R7 level. While not armed, ref_out is low when counting up and high when counting down.
- R10: In mode 12, refc_out is ref_out OR pair_ref. In mode 13, it is ref_out AND pair_ref. refc_out follows pair_ref within the same cycle.
- R11: In modes 14 and 15, refc_out equals ref_out while cnt_down is 0 and equals pair_ref while cnt_down is 1.
- R12: A write (mode_wr high with mode_wdata) always updates the shadow mode. With preload_en low, it also updates the active mode at the same edge, and commute has no effect. With preload_en high, the active mode is unchanged except at a commute pulse, which loads the shadow value held before that edge.
- R13: While lock and chan_is_output are both high, a mode write changes neither the shadow mode nor the active mode.
- R14: In modes 0 to 11, refc_out equals ref_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| cmp_val | input | CNT_W | Compare value |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | Mode code to write |
| preload_en | input | 1 | Route mode writes through the shadow copy |
| commute | input | 1 | Commutation pulse: shadow to active |
| lock | input | 1 | Mode write lock |
| chan_is_output | input | 1 | Channel is configured as an output |
| trig | input | 1 | Trigger pulse for one-pulse modes |
| upd | input | 1 | Update-event pulse |
| pair_ref | input | 1 | Reference of the paired channel |
| ref_out | output | 1 | Registered active-high reference |
| refc_out | output | 1 | Combined reference |

## Verification
ref_out is registered. Its new level appears after the clock edge that samples the counter, compare, trigger and update inputs. A mode write reaches ref_out one edge later, since the active mode register lies in between. refc_out is combinational from ref_out, pair_ref and cnt_down, so it changes in the same cycle as those inputs. The bench changes inputs a quarter period after each rising edge. It advances its behavioural model at the rising edge and compares both outputs at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/ocref_pkg.sv
package ocref_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        OC_FROZEN = 4'd0,
        OC_SET    = 4'd1,
        OC_CLR    = 4'd2,
        OC_TOG    = 4'd3,
        OC_FLO    = 4'd4,
        OC_FHI    = 4'd5,
        OC_PWM1   = 4'd6,
        OC_PWM2   = 4'd7,
        OC_OPM1   = 4'd8,
        OC_OPM2   = 4'd9,
        OC_RSV_A  = 4'd10,
        OC_RSV_B  = 4'd11,
        OC_CMB1   = 4'd12,
        OC_CMB2   = 4'd13,
        OC_ASY1   = 4'd14,
        OC_ASY2   = 4'd15
    } oc_mode_e;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } cmp_s;

    // PWM level for the given polarity (inv=0 first polarity, inv=1 second)
    function automatic logic pwm_level(input logic inv, input logic down, input cmp_s c);
        logic lvl;
        lvl = down ? !c.gt : c.lt;
        return lvl ^ inv;
    endfunction

    function automatic logic is_second_pol(input oc_mode_e m);
        return (m == OC_PWM2) || (m == OC_OPM2) || (m == OC_CMB2) || (m == OC_ASY2);
    endfunction

    function automatic logic is_one_pulse(input oc_mode_e m);
        return (m == OC_OPM1) || (m == OC_OPM2);
    endfunction

endpackage

// File: rtl/ocref_mode_reg.sv
module ocref_mode_reg
    import ocref_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              preload_en,
    input  logic              commute,
    input  logic              lock,
    input  logic              is_out,
    output oc_mode_e          active_q
);

    oc_mode_e shadow_q;
    logic     wr_ok;

    assign wr_ok = wr && !(lock && is_out);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= OC_FROZEN;
            active_q <= OC_FROZEN;
        end else begin
            if (wr_ok) begin
                shadow_q <= oc_mode_e'(wdata);
            end
            if (preload_en) begin
                if (commute) begin
                    active_q <= shadow_q;
                end
            end else if (wr_ok) begin
                active_q <= oc_mode_e'(wdata);
            end
        end
    end

    assert_preload_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (preload_en && !commute) |=> $stable(active_q));

    assert_lock_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (lock && is_out && !(preload_en && commute)) |=> $stable(active_q));

    assert_lock_shadow_R13: assert property (@(posedge clk) disable iff (rst)
        (lock && is_out) |=> $stable(shadow_q));

endmodule

// File: rtl/ocref_core.sv
module ocref_core
    import ocref_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  oc_mode_e         mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_down,
    input  logic             trig,
    input  logic             upd,
    output logic             ref_q
);

    cmp_s c;
    logic armed_q;
    logic armed_nxt;
    logic ref_nxt;
    logic idle_lvl;

    always_comb begin
        c.eq = (cnt == cmp_val);
        c.lt = (cnt < cmp_val);
        c.gt = (cnt > cmp_val);
    end

    always_comb begin
        if (is_one_pulse(mode)) begin
            armed_nxt = trig ? 1'b1 : (upd ? 1'b0 : armed_q);
        end else begin
            armed_nxt = 1'b0;
        end
        // Idle level of a one-pulse mode: first polarity is high counting up
        idle_lvl = (!cnt_down) ^ is_second_pol(mode);
    end

    always_comb begin
        ref_nxt = ref_q;
        case (mode)
            OC_SET:  if (c.eq) ref_nxt = 1'b1;
            OC_CLR:  if (c.eq) ref_nxt = 1'b0;
            OC_TOG:  if (c.eq) ref_nxt = !ref_q;
            OC_FLO:  ref_nxt = 1'b0;
            OC_FHI:  ref_nxt = 1'b1;
            OC_PWM1, OC_PWM2, OC_CMB1, OC_CMB2, OC_ASY1, OC_ASY2:
                ref_nxt = pwm_level(is_second_pol(mode), cnt_down, c);
            OC_OPM1, OC_OPM2:
                ref_nxt = armed_nxt ? pwm_level(is_second_pol(mode), cnt_down, c) : idle_lvl;
            default: ref_nxt = ref_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ref_q   <= ref_nxt;
            armed_q <= armed_nxt;
        end
    end

    assert_frozen_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_FROZEN || mode == OC_RSV_A || mode == OC_RSV_B) |=> $stable(ref_q));

    assert_set_match_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_SET && cnt == cmp_val) |=> ref_q);

    assert_toggle_match_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_TOG && cnt == cmp_val) |=> (ref_q != $past(ref_q)));

    assert_force_high_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_FHI) |=> ref_q);

    assert_force_low_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_FLO) |=> !ref_q);

    assert_opm_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_OPM1 && !trig && !armed_q && !cnt_down) |=> ref_q);

endmodule

// File: rtl/ocref_combine.sv
module ocref_combine
    import ocref_pkg::*;
(
    input  oc_mode_e mode,
    input  logic     ref_in,
    input  logic     pair_ref,
    input  logic     cnt_down,
    output logic     refc
);

    always_comb begin
        case (mode)
            OC_CMB1:          refc = ref_in | pair_ref;
            OC_CMB2:          refc = ref_in & pair_ref;
            OC_ASY1, OC_ASY2: refc = cnt_down ? pair_ref : ref_in;
            default:          refc = ref_in;
        endcase
    end

endmodule

// File: rtl/ocref_gen.sv
module ocref_gen
    import ocref_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cnt_down,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              preload_en,
    input  logic              commute,
    input  logic              lock,
    input  logic              chan_is_output,
    input  logic              trig,
    input  logic              upd,
    input  logic              pair_ref,
    output logic              ref_out,
    output logic              refc_out
);

    oc_mode_e active_mode;

    ocref_mode_reg u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr         (mode_wr),
        .wdata      (mode_wdata),
        .preload_en (preload_en),
        .commute    (commute),
        .lock       (lock),
        .is_out     (chan_is_output),
        .active_q   (active_mode)
    );

    ocref_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .mode     (active_mode),
        .cnt      (cnt),
        .cmp_val  (cmp_val),
        .cnt_down (cnt_down),
        .trig     (trig),
        .upd      (upd),
        .ref_q    (ref_out)
    );

    ocref_combine u_comb (
        .mode     (active_mode),
        .ref_in   (ref_out),
        .pair_ref (pair_ref),
        .cnt_down (cnt_down),
        .refc     (refc_out)
    );

endmodule

// File: tb/ocref_gen_bench.sv
module ocref_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cnt = 8'd0;
    logic       cnt_down = 1'b0;
    logic [7:0] cmp_val = 8'd8;
    logic       mode_wr = 1'b0;
    logic [3:0] mode_wdata = 4'd0;
    logic       preload_en = 1'b0;
    logic       commute = 1'b0;
    logic       lock = 1'b0;
    logic       chan_is_output = 1'b0;
    logic       trig = 1'b0;
    logic       upd = 1'b0;
    logic       pair_ref = 1'b0;
    logic       ref_out;
    logic       refc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit go       = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int m_act = 0;
    int m_shd = 0;
    bit m_ref = 1'b0;
    bit m_arm = 1'b0;

    always #10 clk = !clk;

    ocref_gen #(.CNT_W(8)) u_ocref_gen (
        .clk(clk), .rst(rst), .cnt(cnt), .cnt_down(cnt_down), .cmp_val(cmp_val),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .preload_en(preload_en),
        .commute(commute), .lock(lock), .chan_is_output(chan_is_output),
        .trig(trig), .upd(upd), .pair_ref(pair_ref),
        .ref_out(ref_out), .refc_out(refc_out)
    );

    function automatic bit pwm_ref(bit inv);
        bit v;
        if (cnt_down) v = !(cnt > cmp_val);
        else          v = (cnt < cmp_val);
        return v ^ inv;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_shd = 0; m_ref = 1'b0; m_arm = 1'b0;
        end else begin
            bit armn;
            bit eq;
            bit wr_ok;
            eq = (cnt == cmp_val);
            if (m_act == 8 || m_act == 9) armn = trig ? 1'b1 : (upd ? 1'b0 : m_arm);
            else armn = 1'b0;
            case (m_act)
                1: if (eq) m_ref = 1'b1;
                2: if (eq) m_ref = 1'b0;
                3: if (eq) m_ref = !m_ref;
                4: m_ref = 1'b0;
                5: m_ref = 1'b1;
                6, 12, 14: m_ref = pwm_ref(1'b0);
                7, 13, 15: m_ref = pwm_ref(1'b1);
                8: m_ref = armn ? pwm_ref(1'b0) : !cnt_down;
                9: m_ref = armn ? pwm_ref(1'b1) : cnt_down;
                default: ;
            endcase
            m_arm = armn;
            wr_ok = mode_wr && !(lock && chan_is_output);
            if (preload_en) begin
                if (commute) m_act = m_shd;
                if (wr_ok) m_shd = int'(mode_wdata);
            end else if (wr_ok) begin
                m_shd = int'(mode_wdata);
                m_act = int'(mode_wdata);
            end
        end
    end

    function automatic bit exp_refc();
        case (m_act)
            12: return m_ref | pair_ref;
            13: return m_ref & pair_ref;
            14, 15: return cnt_down ? pair_ref : m_ref;
            default: return m_ref;
        endcase
    endfunction

    task automatic chk(string req, string what, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (go) begin
            chk(cur_req, "ref_out", ref_out, m_ref);
            chk((m_act >= 12) ? cur_req : "R14", "refc_out", refc_out, exp_refc());
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic wr_mode(int m);
        mode_wdata = 4'(m);
        mode_wr = 1'b1;
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic sweep(bit down, int start, int n);
        for (int i = 0; i < n; i++) begin
            cnt_down = down;
            cnt = down ? 8'(start - i) : 8'(start + i);
            pair_ref = (i % 3 == 0);
            tick();
        end
    endtask

    task automatic pulse_trig();
        trig = 1'b1; tick(); trig = 1'b0;
    endtask

    task automatic pulse_upd();
        upd = 1'b1; tick(); upd = 1'b0;
    endtask

    task automatic pulse_commute();
        commute = 1'b1; tick(); commute = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        tick(); go = 1'b1;
        tick(); tick();
        rst = 1'b0;
        // R1: explicit reset-state checks before any write
        chk("R1", "ref_out after reset", ref_out, 1'b0);
        chk("R1", "refc_out after reset", refc_out, 1'b0);
        sweep(1'b0, 0, 12);

        cur_req = "R5";
        wr_mode(5); sweep(1'b0, 0, 16);
        wr_mode(4); sweep(1'b0, 0, 16);
        wr_mode(5); sweep(1'b1, 15, 4);

        cur_req = "R2";
        wr_mode(0); sweep(1'b0, 0, 16);
        wr_mode(10); sweep(1'b1, 15, 16);
        wr_mode(4); tick();
        wr_mode(11); sweep(1'b0, 0, 16);

        cur_req = "R3";
        wr_mode(1); sweep(1'b0, 0, 16);
        wr_mode(2); sweep(1'b1, 15, 16);

        cur_req = "R4";
        wr_mode(3); sweep(1'b0, 0, 16); sweep(1'b1, 15, 16);
        cmp_val = 8'd0; sweep(1'b0, 0, 6);
        cmp_val = 8'd8;

        cur_req = "R6";
        wr_mode(6); sweep(1'b0, 0, 16); sweep(1'b1, 15, 16);
        cur_req = "R7";
        wr_mode(7); sweep(1'b0, 0, 16); sweep(1'b1, 15, 16);

        cur_req = "R8";
        wr_mode(8); sweep(1'b0, 0, 6);
        cnt = 8'd3; pulse_trig(); sweep(1'b0, 4, 10);
        pulse_upd(); sweep(1'b0, 0, 10);
        cnt_down = 1'b1; cnt = 8'd12; pulse_trig(); sweep(1'b1, 11, 10);
        trig = 1'b1; upd = 1'b1; tick(); trig = 1'b0; upd = 1'b0;
        sweep(1'b1, 9, 4); pulse_upd(); sweep(1'b1, 15, 6);

        cur_req = "R9";
        wr_mode(9); sweep(1'b0, 0, 6);
        cnt = 8'd2; pulse_trig(); sweep(1'b0, 3, 12);
        pulse_upd(); sweep(1'b1, 15, 8);
        pulse_trig(); sweep(1'b1, 7, 8);

        cur_req = "R10";
        wr_mode(12); sweep(1'b0, 0, 16); sweep(1'b1, 15, 16);
        wr_mode(13); sweep(1'b0, 0, 16); sweep(1'b1, 15, 16);

        cur_req = "R11";
        wr_mode(14); sweep(1'b0, 0, 16); sweep(1'b1, 15, 16);
        wr_mode(15); sweep(1'b0, 0, 16); sweep(1'b1, 15, 16);

        cur_req = "R12";
        wr_mode(5); tick();
        preload_en = 1'b1;
        wr_mode(4); sweep(1'b0, 0, 6);
        pulse_commute(); sweep(1'b0, 0, 4);
        wr_mode(5); sweep(1'b0, 0, 4);
        mode_wdata = 4'd6; mode_wr = 1'b1; commute = 1'b1; tick();
        mode_wr = 1'b0; commute = 1'b0;
        sweep(1'b0, 0, 6);
        pulse_commute(); sweep(1'b0, 0, 16);
        preload_en = 1'b0;
        pulse_commute(); sweep(1'b0, 0, 4);

        cur_req = "R13";
        wr_mode(5); tick();
        lock = 1'b1; chan_is_output = 1'b1;
        wr_mode(4); sweep(1'b0, 0, 6);
        preload_en = 1'b1; wr_mode(4); pulse_commute(); sweep(1'b0, 0, 6);
        preload_en = 1'b0;
        chan_is_output = 1'b0; wr_mode(4); sweep(1'b0, 0, 4);
        lock = 1'b0; wr_mode(5); sweep(1'b0, 0, 4);

        go = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule